// File: doc/BRIEF.md
# Variable-Amount Shift, Rotate and Bit-Reverse Accumulator Unit

This block is a one-cycle accumulator datapath for bit-level stream formatting. It holds an accumulator and a small file of general registers. Shift and rotate operations take their distance from the contents of a chosen register rather than from a field of the instruction. A native whole-word bit reversal and a register-to-accumulator XOR let a stored mask complement selected bits.

Each cycle in which `op_valid` is high, the 4-bit `opcode` names one operation and `reg_idx` names the register that supplies the amount, the operand or the store target. The result lands in the accumulator at the next rising clock edge. A zero flag tracks the accumulator. The surrounding sequencer drives one operation per cycle and reads the accumulator directly.

Top module: `bsr_accum_unit`

## Requirements
- R1: After reset the accumulator is 0, the zero flag is 1 and every general register reads 0.
- R2: Opcode 3 writes `literal` into register `reg_idx` and leaves the accumulator unchanged; opcode 1 copies register `reg_idx` into the accumulator.
- R3: Opcode 2 copies the accumulator into register `reg_idx` and leaves the accumulator unchanged.
- R4: Opcode 4 shifts the accumulator left, filling with zeros, by the unsigned value held in register `reg_idx`; a value of DATA_W or more gives 0.
- R5: Opcode 5 shifts the accumulator right, filling with zeros, by the register value; a value of DATA_W or more gives 0.
- R6: Opcode 6 rotates the accumulator left by the register value modulo DATA_W.
- R7: Opcode 7 rotates the accumulator right by the register value modulo DATA_W.
- R8: Opcode 8 reverses the accumulator end for end, so that bit i moves to bit DATA_W-1-i.
- R9: Opcode 9 replaces the accumulator with its bitwise XOR with register `reg_idx`.
- R10: The zero flag is 1 exactly when the accumulator is 0, and it is updated together with the accumulator.
- R11: Register indices of NUM_REGS and above (index 15 by default) read as 0, and writes to them are discarded.
- R12: When `op_valid` is low, and for opcode 0 or opcodes 10 to 15, neither the accumulator nor any register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Execute the presented operation this cycle |
| opcode | input | 4 | Operation select |
| reg_idx | input | IDX_W (4) | Register for amount, operand or store target |
| literal | input | DATA_W (8) | Immediate value for the register-load operation |
| acc_o | output | DATA_W (8) | Accumulator contents |
| zero_o | output | 1 | High when the accumulator is zero |

## Verification
The bench sweeps shift and rotate distances of 0, 1, 3 and 7, then DATA_W, DATA_W+1 and a large value such as 200. A design that took shift distances modulo the width would return a rotated or shifted value instead of zero at 8 and 9. A design that range-checked rotates would zero the result instead of rotating by 200 mod 8. The sweep uses asymmetric patterns, so a swapped direction or a rotate that drops its wrapped bits changes the result. The bench also targets index 15 as a read, store and XOR source, an XOR of the accumulator with a copy of itself so that the zero flag must rise, and register loads attempted with `op_valid` low. A decoder that ignored the valid qualifier or the unused index would leave visible changes in the accumulator read back afterwards.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [3:0] {
    OP_NOP = 4'd0,
    OP_LDA = 4'd1,
    OP_STA = 4'd2,
    OP_LDI = 4'd3,
    OP_SHL = 4'd4,
    OP_SHR = 4'd5,
    OP_ROL = 4'd6,
    OP_ROR = 4'd7,
    OP_REV = 4'd8,
    OP_XOR = 4'd9
  } bsr_op_e;
endpackage

// File: rtl/bsr_regfile.sv
module bsr_regfile #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 15,
  parameter int IDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic              hit;
    logic [DATA_W-1:0] cell_q;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cell_q <= '0;
      else if (hit) cell_q <= wr_data;
    end
    assign regs_q[g] = cell_q;
  end

  // Indices without a register read as zero (R11)
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = regs_q[i];
    end
  end
endmodule

// File: rtl/bsr_barrel.sv
module bsr_barrel #(
  parameter int DATA_W = 8,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] amount_i,
  input  logic              right_i,
  input  logic              rotate_i,
  output logic [DATA_W-1:0] shift_o,
  output logic [DATA_W-1:0] rev_o
);
  localparam int STAGES = AMT_W;

  function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  logic [DATA_W-1:0] stage [STAGES+1];
  logic              over_range;
  logic [DATA_W-1:0] left_res;

  // Right-hand operations reuse the left network between two reversals
  assign stage[0] = right_i ? flip(data_i) : data_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int SH = 1 << s;
    logic [DATA_W-1:0] moved;
    assign moved = rotate_i ? {stage[s][DATA_W-1-SH:0], stage[s][DATA_W-1 -: SH]}
                            : {stage[s][DATA_W-1-SH:0], {SH{1'b0}}};
    assign stage[s+1] = amount_i[s] ? moved : stage[s];
  end

  assign over_range = |amount_i[DATA_W-1:AMT_W];
  assign left_res   = right_i ? flip(stage[STAGES]) : stage[STAGES];
  assign shift_o    = (!rotate_i && over_range) ? '0 : left_res;
  assign rev_o      = flip(data_i);
endmodule

// File: rtl/bsr_accum_unit.sv
module bsr_accum_unit
  import bsr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 15,
  parameter int IDX_W    = $clog2(NUM_REGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        opcode,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] literal,
  output logic [DATA_W-1:0] acc_o,
  output logic              zero_o
);
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              zero_q, zero_d;
  logic              acc_en;
  logic [DATA_W-1:0] rf_rd, rf_wdata;
  logic              rf_we;
  logic              sh_right, sh_rotate;
  logic [DATA_W-1:0] sh_res, rev_res;
  bsr_op_e           op;

  assign op = bsr_op_e'(opcode);

  bsr_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(rf_we), .wr_idx(reg_idx),
    .wr_data(rf_wdata), .rd_idx(reg_idx), .rd_data(rf_rd)
  );

  assign sh_right  = (op == OP_SHR) || (op == OP_ROR);
  assign sh_rotate = (op == OP_ROL) || (op == OP_ROR);

  bsr_barrel #(.DATA_W(DATA_W)) u_net (
    .data_i(acc_q), .amount_i(rf_rd), .right_i(sh_right),
    .rotate_i(sh_rotate), .shift_o(sh_res), .rev_o(rev_res)
  );

  // Next-state decode
  always_comb begin
    acc_d    = acc_q;
    rf_we    = 1'b0;
    rf_wdata = acc_q;
    if (op_valid) begin
      case (op)
        OP_LDA: acc_d = rf_rd;
        OP_STA: rf_we = 1'b1;
        OP_LDI: begin
          rf_we    = 1'b1;
          rf_wdata = literal;
        end
        OP_SHL, OP_SHR, OP_ROL, OP_ROR: acc_d = sh_res;
        OP_REV: acc_d = rev_res;
        OP_XOR: acc_d = acc_q ^ rf_rd;
        default: acc_d = acc_q;
      endcase
    end
  end

  assign acc_en = op_valid;
  assign zero_d = (acc_d == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      zero_q <= 1'b1;
    end else if (acc_en) begin
      acc_q  <= acc_d;
      zero_q <= zero_d;
    end
  end

  assign acc_o  = acc_q;
  assign zero_o = zero_q;
endmodule

// File: rtl/bsr_accum_chk.sv
module bsr_accum_chk #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 15,
  parameter int IDX_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [3:0]        opcode,
  input logic [IDX_W-1:0]  reg_idx,
  input logic [DATA_W-1:0] acc_o,
  input logic              zero_o,
  input logic [DATA_W-1:0] rd_data
);
  p_load_acc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 4'd1) |=> acc_o == $past(rd_data));

  p_shift_over_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (opcode == 4'd4 || opcode == 4'd5) && rd_data >= DATA_W) |=> acc_o == '0);

  p_rot_keeps_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (opcode == 4'd6 || opcode == 4'd7 || opcode == 4'd8))
      |=> $countones(acc_o) == $countones($past(acc_o)));

  p_xor_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 4'd9) |=> acc_o == ($past(acc_o) ^ $past(rd_data)));

  p_zero_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o == (acc_o == '0));

  p_no_reg_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx >= IDX_W'(NUM_REGS)) |-> rd_data == '0);

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(acc_o));
endmodule

bind bsr_accum_unit bsr_accum_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
  .reg_idx(reg_idx), .acc_o(acc_o), .zero_o(zero_o), .rd_data(rf_rd)
);

// File: tb/sim_bsr_accum_unit.sv
`timescale 1ns/1ps
module sim_bsr_accum_unit;
  localparam int W  = 8;
  localparam int NR = 15;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          op_valid;
  logic [3:0]    opcode;
  logic [IW-1:0] reg_idx;
  logic [W-1:0]  literal;
  logic [W-1:0]  acc_o;
  logic          zero_o;

  always #4 clk = ~clk;

  bsr_accum_unit #(.DATA_W(W), .NUM_REGS(NR)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .reg_idx(reg_idx), .literal(literal), .acc_o(acc_o), .zero_o(zero_o)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [W-1:0] m_regs [NR];
  logic [W-1:0] m_acc;
  logic [W-1:0] q_acc [$];
  string        q_tag [$];

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] m_read(input int idx);
    return (idx < NR) ? m_regs[idx] : '0;
  endfunction

  function automatic logic [W-1:0] m_rot(input logic [W-1:0] v, input int a, input bit right);
    logic [W-1:0] r = v;
    for (int k = 0; k < (a % W); k++)
      r = right ? {r[0], r[W-1:1]} : {r[W-2:0], r[W-1]};
    return r;
  endfunction

  function automatic logic [W-1:0] m_rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  // Driver: presents one operation and queues the expected accumulator
  task automatic issue(input bit v, input int op, input int idx, input logic [W-1:0] lit,
                       input string tag);
    int amt;
    @(negedge clk);
    op_valid = v;
    opcode   = op[3:0];
    reg_idx  = idx[IW-1:0];
    literal  = lit;
    amt      = int'(m_read(idx));
    if (v) begin
      case (op)
        1: m_acc = m_read(idx);
        2: if (idx < NR) m_regs[idx] = m_acc;
        3: if (idx < NR) m_regs[idx] = lit;
        4: m_acc = (amt >= W) ? '0 : (m_acc << amt);
        5: m_acc = (amt >= W) ? '0 : (m_acc >> amt);
        6: m_acc = m_rot(m_acc, amt, 1'b0);
        7: m_acc = m_rot(m_acc, amt, 1'b1);
        8: m_acc = m_rev(m_acc);
        9: m_acc = m_acc ^ m_read(idx);
        default: ;
      endcase
    end
    q_acc.push_back(m_acc);
    q_tag.push_back(tag);
  endtask

  // Monitor: compares after each edge
  always @(posedge clk) begin
    #2;
    if (q_acc.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = q_acc.pop_front();
      t = q_tag.pop_front();
      chk({t, " acc"}, acc_o, e);
      chk({t, " zero R10"}, W'(zero_o), W'(e == '0));
    end
  end

  task automatic run_sh(input int op, input logic [W-1:0] val, input logic [W-1:0] amt,
                        input string tag);
    issue(1, 3, 2, val, "R2 ldi");
    issue(1, 1, 2, '0, "R2 lda");
    issue(1, 3, 3, amt, "R2 ldi amt");
    issue(1, op, 3, '0, tag);
  endtask

  task automatic finish_run();
    @(negedge clk);
    op_valid = 1'b0;
    repeat (4) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] vals [5] = '{8'hB4, 8'h81, 8'h01, 8'hFF, 8'h5A};
    logic [W-1:0] amts [7] = '{8'd0, 8'd1, 8'd3, 8'd7, 8'd8, 8'd9, 8'd200};
    string names [4] = '{"R4 shl", "R5 shr", "R6 rol", "R7 ror"};
    for (int i = 0; i < NR; i++) m_regs[i] = '0;
    m_acc    = '0;
    rst_n    = 1'b0;
    op_valid = 1'b0;
    opcode   = '0;
    reg_idx  = '0;
    literal  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset acc", acc_o, '0);
    chk("R1 reset zero", W'(zero_o), W'(1));
    issue(1, 1, 5, '0, "R1 reg after reset");
    issue(1, 1, 14, '0, "R1 top reg after reset");

    issue(1, 3, 0, 8'hB4, "R2 ldi keeps acc");
    issue(1, 1, 0, '0, "R2 lda");

    for (int o = 0; o < 4; o++)
      for (int v = 0; v < 5; v++)
        for (int a = 0; a < 7; a++)
          run_sh(4 + o, vals[v], amts[a], names[o]);

    for (int v = 0; v < 5; v++) begin
      issue(1, 3, 2, vals[v] ^ 8'h0F, "R2 ldi");
      issue(1, 1, 2, '0, "R2 lda");
      issue(1, 8, 2, '0, "R8 rev");
    end

    issue(1, 3, 4, 8'h2A, "R2 ldi mask");
    issue(1, 3, 5, 8'hC3, "R2 ldi");
    issue(1, 1, 5, '0, "R2 lda");
    issue(1, 9, 4, '0, "R9 xor mask");
    issue(1, 2, 6, '0, "R3 sta keeps acc");
    issue(1, 3, 7, 8'h00, "R2 ldi");
    issue(1, 1, 7, '0, "R2 lda zero");
    issue(1, 1, 6, '0, "R3 stored value");
    issue(1, 9, 6, '0, "R10 xor self to zero");
    issue(1, 9, 4, '0, "R10 zero clears");

    issue(1, 3, 15, 8'hFF, "R11 ldi idx15");
    issue(1, 1, 15, '0, "R11 read idx15");
    issue(1, 3, 8, 8'h77, "R2 ldi");
    issue(1, 1, 8, '0, "R2 lda");
    issue(1, 2, 15, '0, "R11 sta idx15");
    issue(1, 9, 15, '0, "R11 xor idx15");
    issue(1, 1, 15, '0, "R11 idx15 still zero");
    issue(1, 4, 15, '0, "R11 shl by idx15");

    issue(0, 4, 3, '0, "R12 invalid shl");
    issue(0, 3, 9, 8'h55, "R12 invalid ldi");
    issue(1, 1, 9, '0, "R12 reg untouched");
    issue(1, 1, 8, '0, "R2 lda");
    issue(1, 0, 8, 8'h11, "R12 nop");
    issue(1, 12, 3, 8'h22, "R12 undefined op");
    issue(1, 15, 3, 8'h33, "R12 undefined op");
    issue(1, 1, 3, '0, "R12 regs kept");
    finish_run();
  end
endmodule